// File: doc/BRIEF.md
# Four-Channel Shadowed PWM Generator

This block produces four independent pulse-width-modulated outputs from one clock. Each channel is set by two numbers: a period, given in clock ticks, and a level count, which is the number of low ticks at the start of every period when polarity is normal. Software writes these numbers into shadow registers through a simple strobe-based 32-bit register port. The running counters only take new values at two moments: when the channel is started, or after an explicit update handshake.

A channel begins when its start bit goes from 0 to 1. At that point it captures both shadow values and begins a period with its low phase. To change a running waveform, software first writes new shadow values. It then writes 1 and then 0 to the channel's update bit. The values held at the falling write are staged and become active at the next period boundary, so no period is ever cut short. Each channel also has:

- a polarity bit that inverts its output;
- an output-enable bit, which decides whether the pad driver is turned on;
- a read-only done bit, which pulses in the last tick of each period.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After reset, every period register reads 2 and every level register reads 1. The polarity, start, update, output-enable and done registers read 0. `pwm_out` and `pwm_oe` are all 0.
- R2: Register map, with bit n of each shared register controlling channel n:
  - the level register of channel n is at byte offset n*8 and the period register at n*8+4 (30 bits, upper bits read 0);
  - polarity is at 0x40, start at 0x44, done at 0x48, update at 0x4C and output enable at 0xD0.
  - When `rd_en` is 1, `rdata` shows the addressed register in the same cycle; otherwise `rdata` is 0.
- R3: A 0-to-1 write of a start bit copies that channel's shadow period and level into the channel. The first output tick of the new waveform comes two clock edges after the write edge and is in the low phase.
- R4: While a channel runs, shadow writes made without the update handshake leave its waveform unchanged.
- R5: Writing 1 and then 0 to an update bit stages the shadow values present at the 0 write. They take effect at the next period boundary. A write of 1 alone changes nothing, and every period across a change is the full old or the full new length.
- R6: With period P and level L under polarity 0, each period has L low ticks followed by P-L high ticks. L=0 gives a constantly high output and L>=P gives a constantly low output. Channels run independently.
- R7: A polarity bit of 1 inverts that channel's running output, so it is high for L ticks of each period.
- R8: A channel whose start bit is 0 drives `pwm_out` low from the second clock edge after the clearing write, whatever its polarity.
- R9: `pwm_oe[n]` follows the output-enable bit of channel n. While that bit is 0, `pwm_out[n]` is 0 but the channel keeps counting.
- R10: A running channel's done bit is 1 for exactly one clock, in the last tick of each period. The bit is 0 when the channel is stopped, and writes to the done register have no effect.
- R11: A period value below 2 is run as 2, so the fastest output is half the clock rate. The register still reads back the value that was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe; gates `rdata` |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| pwm_out | output | 4 | Waveform value per channel |
| pwm_oe | output | 4 | Pad driver enable per channel |

## Verification
The risky overlap is an update handshake whose closing 0 write lands in the same cycle as the channel's period boundary. In that case the load of the staged values and the start of a new period compete, and the result could be a truncated period or values applied one period early. The bench makes this happen by repeating the handshake on a running channel, switching its period between 5 and 7 ticks and shifting the write phase by one extra cycle each round, so that every alignment with the boundary occurs. A monitor measures the spacing of successive rising edges on the output. Any spacing other than 5 or 7 is reported as a truncated period, and after the last round the spacing must settle at the final value.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

    // byte offsets of the shared per-channel bit registers
    localparam int OFS_POL   = 'h40;
    localparam int OFS_START = 'h44;
    localparam int OFS_DONE  = 'h48;
    localparam int OFS_UPD   = 'h4C;
    localparam int OFS_OE    = 'hD0;

    // per-channel control bundle handed from the register file to a channel
    typedef struct packed {
        logic start;       // start bit level
        logic start_rise;  // one-cycle pulse after a 0->1 write of start
        logic upd_fall;    // one-cycle pulse after a 1->0 write of update
        logic pol;         // invert output
        logic oe;          // drive the pad
    } chan_ctl_t;

    // smallest period the counter can run
    function automatic logic [31:0] fit_period(input logic [31:0] v);
        return (v < 32'd2) ? 32'd2 : v;
    endfunction

endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_shadow_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 30,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    input  logic [NCH-1:0]           done_i,
    output logic [NCH-1:0][CW-1:0]   sh_per,
    output logic [NCH-1:0][CW-1:0]   sh_lvl,
    output chan_ctl_t [NCH-1:0]      ctl
);
    localparam int CH_SPAN = NCH * 8;
    localparam int IW      = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0] pol_q, start_q, upd_q, oe_q, srise_q, ufall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                sh_per[i] <= CW'(2);
                sh_lvl[i] <= CW'(1);
            end
            pol_q   <= '0;
            start_q <= '0;
            upd_q   <= '0;
            oe_q    <= '0;
            srise_q <= '0;
            ufall_q <= '0;
        end else begin
            srise_q <= '0;
            ufall_q <= '0;
            if (wr_en) begin
                for (int i = 0; i < NCH; i++) begin
                    if (addr == AW'(i * 8))     sh_lvl[i] <= wdata[CW-1:0];
                    if (addr == AW'(i * 8 + 4)) sh_per[i] <= wdata[CW-1:0];
                end
                if (addr == AW'(OFS_POL)) pol_q <= wdata[NCH-1:0];
                if (addr == AW'(OFS_OE))  oe_q  <= wdata[NCH-1:0];
                if (addr == AW'(OFS_START)) begin
                    start_q <= wdata[NCH-1:0];
                    srise_q <= wdata[NCH-1:0] & ~start_q;
                end
                if (addr == AW'(OFS_UPD)) begin
                    upd_q   <= wdata[NCH-1:0];
                    ufall_q <= ~wdata[NCH-1:0] & upd_q;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ctl[i].start      = start_q[i];
            ctl[i].start_rise = srise_q[i];
            ctl[i].upd_fall   = ufall_q[i];
            ctl[i].pol        = pol_q[i];
            ctl[i].oe         = oe_q[i];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr < AW'(CH_SPAN) && addr[1:0] == 2'b00) begin
                if (addr[2]) rdata[CW-1:0] = sh_per[addr[3 +: IW]];
                else         rdata[CW-1:0] = sh_lvl[addr[3 +: IW]];
            end else if (addr == AW'(OFS_POL))   rdata[NCH-1:0] = pol_q;
            else if (addr == AW'(OFS_START))     rdata[NCH-1:0] = start_q;
            else if (addr == AW'(OFS_DONE))      rdata[NCH-1:0] = done_i;
            else if (addr == AW'(OFS_UPD))       rdata[NCH-1:0] = upd_q;
            else if (addr == AW'(OFS_OE))        rdata[NCH-1:0] = oe_q;
        end
    end

    AST_RISE_WITH_START: assert property (@(posedge clk) disable iff (rst)
        (srise_q != '0) |-> ((srise_q & ~start_q) == '0)); // R3

endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
    import pwm_shadow_pkg::*;
#(
    parameter int CW = 30
) (
    input  logic          clk,
    input  logic          rst,
    input  chan_ctl_t     ctl,
    input  logic [CW-1:0] sh_per,
    input  logic [CW-1:0] sh_lvl,
    output logic          pwm_o,
    output logic          oe_o,
    output logic          done_o
);
    localparam logic [CW-1:0] PER_RST = CW'(2);
    localparam logic [CW-1:0] LVL_RST = CW'(1);

    logic          run;
    logic [CW-1:0] cnt, per_a, lvl_a, stg_per, stg_lvl, eff_per;
    logic          pend, last;

    assign eff_per = CW'(fit_period(32'(sh_per)));
    assign last    = (cnt == per_a - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            cnt     <= '0;
            per_a   <= PER_RST;
            lvl_a   <= LVL_RST;
            stg_per <= PER_RST;
            stg_lvl <= LVL_RST;
            pend    <= 1'b0;
        end else if (!ctl.start) begin
            run  <= 1'b0;
            cnt  <= '0;
            pend <= 1'b0;
        end else if (ctl.start_rise) begin
            run   <= 1'b1;
            cnt   <= '0;
            per_a <= eff_per;
            lvl_a <= sh_lvl;
            pend  <= 1'b0;
        end else if (run) begin
            if (last) begin
                cnt <= '0;
                if (pend) begin
                    per_a <= stg_per;
                    lvl_a <= stg_lvl;
                    pend  <= 1'b0;
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
            if (ctl.upd_fall) begin
                stg_per <= eff_per;
                stg_lvl <= sh_lvl;
                pend    <= 1'b1;
            end
        end
    end

    assign pwm_o  = run & ctl.oe & ((cnt >= lvl_a) ^ ctl.pol);
    assign oe_o   = ctl.oe;
    assign done_o = run & last;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < per_a)); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10
    AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (ctl.start && !ctl.start_rise && !(run && last)) |=> ($stable(per_a) && $stable(lvl_a))); // R4
    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        ctl.start_rise |=> (run && cnt == '0)); // R3
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !ctl.start |=> !pwm_o); // R8

endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
    import pwm_shadow_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 30,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] pwm_out,
    output logic [NCH-1:0] pwm_oe
);
    logic [NCH-1:0][CW-1:0] sh_per, sh_lvl;
    chan_ctl_t [NCH-1:0]    ctl;
    logic [NCH-1:0]         done;

    pwm_shadow_regs #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .done_i (done),
        .sh_per (sh_per),
        .sh_lvl (sh_lvl),
        .ctl    (ctl)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwm_shadow_chan #(.CW(CW)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl[g]),
            .sh_per (sh_per[g]),
            .sh_lvl (sh_lvl[g]),
            .pwm_o  (pwm_out[g]),
            .oe_o   (pwm_oe[g]),
            .done_o (done[g])
        );
    end

    AST_OE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ((pwm_out & ~pwm_oe) == '0)); // R9

endmodule

// File: tb/test_pwm_shadow_gen.sv
module test_pwm_shadow_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_out, pwm_oe;

    int errors = 0;
    int checks = 0;
    logic [3:0] m_start = '0, m_oe = '0, m_pol = '0;

    // rise-spacing monitor for channel 1
    bit mon_en = 0;
    int mon_bad = 0, mon_rises = 0, mon_gap = 0;
    bit mon_seen = 0;
    logic mon_prev = 0;

    always #2 clk = ~clk;

    pwm_shadow_gen i_pwm_shadow_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    always @(negedge clk) begin
        if (!mon_en) begin
            mon_seen = 0;
            mon_gap  = 0;
        end else begin
            mon_gap++;
            if (pwm_out[1] && !mon_prev) begin
                if (mon_seen && mon_gap != 5 && mon_gap != 7) begin
                    mon_bad++;
                    $display("FAIL R5 truncated period: gap=%0d expected 5 or 7", mon_gap);
                end
                mon_seen = 1;
                mon_rises++;
                mon_gap = 0;
            end
        end
        mon_prev = pwm_out[1];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    // count high ticks and done spacing of channel ch over n cycles
    task automatic observe(input int ch, input int n, output int highs,
                           output int ngaps, output int badgaps, input int expgap);
        int lastd = -1;
        highs = 0; ngaps = 0; badgaps = 0;
        @(negedge clk);
        rd_en = 1'b1; addr = 8'h48;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            if (pwm_out[ch]) highs++;
            if (rdata[ch]) begin
                if (lastd >= 0) begin
                    ngaps++;
                    if (k - lastd != expgap) badgaps++;
                end
                lastd = k;
            end
        end
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int c = 0; c < 4; c++) begin
            rd(8'(c * 8), d);     chk(d == 1, "R1 level reset", d, 1);
            rd(8'(c * 8 + 4), d); chk(d == 2, "R1 period reset", d, 2);
        end
        rd(8'h40, d); chk(d == 0, "R1 polarity reset", d, 0);
        rd(8'h44, d); chk(d == 0, "R1 start reset", d, 0);
        rd(8'h48, d); chk(d == 0, "R1 done reset", d, 0);
        rd(8'h4C, d); chk(d == 0, "R1 update reset", d, 0);
        rd(8'hD0, d); chk(d == 0, "R1 oe reset", d, 0);
        chk(pwm_out == 0 && pwm_oe == 0, "R1 outputs reset", {pwm_oe, pwm_out}, 0);
        #1 chk(rdata == 0, "R2 rdata idle zero", rdata, 0);
    endtask

    task automatic t_basic;
        int h, ng, bg;
        logic [3:0] seq;
        wr(8'h00, 3); wr(8'h04, 10);
        m_oe[0] = 1; wr(8'hD0, 32'(m_oe));
        m_start[0] = 1; wr(8'h44, 32'(m_start));
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1 seq[k] = pwm_out[0];
        end
        chk(seq == 4'b1000, "R3 low phase first", seq, 4'b1000);
        repeat (20) @(negedge clk);
        observe(0, 40, h, ng, bg, 10);
        chk(h == 28, "R6 highs P=10 L=3", h, 28);
        chk(ng >= 3 && bg == 0, "R10 done spacing 10", bg, 0);
        wr(8'h48, 32'hF);
        observe(0, 20, h, ng, bg, 10);
        chk(ng >= 1 && bg == 0 && h == 14, "R10 done write ignored", bg, 0);
    endtask

    task automatic t_shadow;
        int h, ng, bg;
        logic [31:0] d;
        wr(8'h00, 2); wr(8'h04, 6);
        rd(8'h04, d); chk(d == 6, "R2 period readback", d, 6);
        observe(0, 40, h, ng, bg, 10);
        chk(h == 28 && bg == 0, "R4 running waveform unchanged", h, 28);
    endtask

    task automatic t_update;
        int h, ng, bg;
        wr(8'h4C, 1);
        observe(0, 40, h, ng, bg, 10);
        chk(h == 28 && bg == 0, "R5 update=1 alone no effect", h, 28);
        wr(8'h4C, 0);
        repeat (25) @(negedge clk);
        observe(0, 36, h, ng, bg, 6);
        chk(h == 24, "R5 new highs after handshake", h, 24);
        chk(ng >= 4 && bg == 0, "R5 new period 6", bg, 0);
    endtask

    task automatic t_polarity;
        int h, ng, bg;
        m_pol[0] = 1; wr(8'h40, 32'(m_pol));
        observe(0, 24, h, ng, bg, 6);
        chk(h == 8, "R7 inverted highs = L", h, 8);
        m_start[0] = 0; wr(8'h44, 32'(m_start));
        @(posedge clk); #1 chk(pwm_out[0] == 0, "R8 low after stop", pwm_out[0], 0);
        observe(0, 12, h, ng, bg, 6);
        chk(h == 0, "R8 stopped inverted channel low", h, 0);
        chk(ng == 0, "R10 no done when stopped", ng, 0);
    endtask

    task automatic t_levels;
        int h, ng, bg, h3;
        wr(8'h10, 0); wr(8'h14, 5);
        wr(8'h18, 9); wr(8'h1C, 4);
        m_oe[2] = 1; m_oe[3] = 1; wr(8'hD0, 32'(m_oe));
        m_start[2] = 1; m_start[3] = 1; wr(8'h44, 32'(m_start));
        repeat (10) @(negedge clk);
        observe(2, 20, h, ng, bg, 5);
        chk(h == 20 && bg == 0, "R6 level 0 full high", h, 20);
        observe(3, 20, h3, ng, bg, 4);
        chk(h3 == 0 && ng >= 3 && bg == 0, "R6 level >= period all low", h3, 0);
        m_oe[2] = 0; wr(8'hD0, 32'(m_oe));
        chk(pwm_oe == m_oe, "R9 oe mirrors", pwm_oe, m_oe);
        observe(2, 20, h, ng, bg, 5);
        chk(h == 0, "R9 undriven output low", h, 0);
        chk(ng >= 3 && bg == 0, "R9 channel keeps counting", bg, 0);
        m_oe[2] = 1; wr(8'hD0, 32'(m_oe));
    endtask

    task automatic t_min;
        int h, ng, bg;
        logic [31:0] d;
        wr(8'h18, 1); wr(8'h1C, 1);
        m_start[3] = 0; wr(8'h44, 32'(m_start));
        m_start[3] = 1; wr(8'h44, 32'(m_start));
        repeat (6) @(negedge clk);
        observe(3, 20, h, ng, bg, 2);
        chk(h == 10, "R11 half-rate highs", h, 10);
        chk(ng >= 8 && bg == 0, "R11 period 1 runs as 2", bg, 0);
        rd(8'h1C, d); chk(d == 1, "R11 raw readback", d, 1);
    endtask

    task automatic t_boundary;
        int h, ng, bg;
        wr(8'h08, 2); wr(8'h0C, 7);
        m_oe[1] = 1; wr(8'hD0, 32'(m_oe));
        m_start[1] = 1; wr(8'h44, 32'(m_start));
        repeat (10) @(negedge clk);
        mon_en = 1;
        for (int i = 0; i < 14; i++) begin
            wr(8'h0C, (i % 2) ? 7 : 5);
            wr(8'h4C, 32'h2);
            wr(8'h4C, 32'h0);
            repeat (i + 3) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        mon_en = 0;
        chk(mon_bad == 0, "R5 no truncated period at boundary", mon_bad, 0);
        chk(mon_rises > 20, "R5 monitor saw edges", mon_rises, 21);
        observe(1, 35, h, ng, bg, 7);
        chk(ng >= 4 && bg == 0 && h == 25, "R5 final period settles", bg, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_shadow();
        t_update();
        t_polarity();
        t_levels();
        t_min();
        t_boundary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule